// File: doc/BRIEF.md
# Monochrome Window Framebuffer Writer

This block keeps a small brightness framebuffer, one byte per pixel, and fills rectangles of it from a packed one-bit-per-pixel byte stream. A window command names the top-left corner, the window width and height, and the row pitch in bits. The writer pulls bytes from a valid/ready stream and takes bits from the least significant end of each byte. It stores the current brightness for every set bit and zero for every clear bit, and it drops the padding bits at the end of each window row. Every store is also shown on a framebuffer write port, so a display engine or a mirror copy can follow the contents.

A separate brightness request changes the global brightness. The block then walks the whole framebuffer, one address per cycle, and moves every lit pixel by the signed difference between the new and old brightness, held inside the lit range. Pixels that are dark stay dark. A command whose rectangle leaves the frame, or whose pitch is shorter than its width, is refused with a one-cycle error pulse.

Top module: `mono_fb_writer`

## Requirements
- R1: A window command is refused when x ≥ FB_W, x + width > FB_W, y ≥ FB_H, y + height > FB_H or pitch < width. `cmdErr` is then high for exactly one cycle, in the cycle after acceptance. No framebuffer write happens, `byteReady` stays low and no `done` pulse is given.
- R2: Bits are taken from each stream byte starting at bit 0 and ending at bit 7. The next byte is requested only after bit 7 of the held byte has been used. Each command starts with a fresh byte.
- R3: Window pixels are written in row-major order, each row from left to right. The pixel at column px and row py goes to address py × FB_W + px.
- R4: A set bit writes the current brightness and a clear bit writes 0.
- R5: After the width pixels of each row, the block takes (pitch − width) more bits from the stream and discards them, the last row included. The bit position is not realigned to a byte, so a command uses exactly ceil(height × pitch / 8) bytes.
- R6: The brightness is 255 after reset. A request of 0 sets it to 1, and any other value is used as given.
- R7: On a brightness request, every nonzero pixel gets (new − old) added and the result is held in 1..255, with one write on the port. Zero pixels are not written.
- R8: The rescale lasts FB_W × FB_H cycles, during which `cmdReady` and `lumaReady` stay low. `lumaReady` is also low while `cmdValid` is high.
- R9: `done` is high for one cycle, in the cycle after the last window bit (pixel or padding) is taken. A command with height 0 or pitch 0 takes no byte and gives `done` in the cycle after acceptance.
- R10: `cmdReady` is high exactly when the block is idle. A command is accepted on a clock edge where `cmdValid` and `cmdReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Window command present |
| cmdX | input | DIM_W | Window left column |
| cmdY | input | DIM_W | Window top row |
| cmdWidth | input | DIM_W | Window width in pixels |
| cmdHeight | input | DIM_W | Window height in rows |
| cmdPitch | input | DIM_W | Bits per source row |
| cmdReady | output | 1 | Block is idle and takes a command |
| byteValid | input | 1 | Stream byte present |
| byteData | input | 8 | Stream byte, bit 0 first |
| byteReady | output | 1 | Block takes the stream byte this cycle |
| lumaValid | input | 1 | Brightness request present |
| lumaReq | input | LUMA_W | Requested brightness |
| lumaReady | output | 1 | Brightness request taken this cycle |
| fbWe | output | 1 | Framebuffer write strobe |
| fbAddr | output | ADDR_W | Framebuffer write address |
| fbData | output | LUMA_W | Framebuffer write value |
| done | output | 1 | Window finished (one-cycle pulse) |
| cmdErr | output | 1 | Window command refused (one-cycle pulse) |

## Verification
The assertions assume that the command fields are sampled only on the acceptance edge and that `lumaReq` is sampled only while `lumaReady` is high. They place no demand on the stream, which may stall in any cycle. The stimulus raises `cmdValid` or `lumaValid` only while the block is idle, and keeps it up for a single cycle. Stream bytes are offered with random gaps and never beyond the count that a command consumes. For refused commands a byte is offered on purpose, to show that it is not taken.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_SCAN
  } fbw_state_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic wantBit;   // window walk wants a bit this cycle
    logic takeBit;   // one bit is consumed this cycle
    logic writePix;  // consumed bit belongs to a window pixel
    logic flush;     // drop any held byte (new command)
    logic loadLuma;  // latch a new brightness
    logic scanStep;  // rescale visits one address
  } fbw_strobe_t;
endpackage

// File: rtl/fbw_ctrl.sv
module fbw_ctrl
  import fbw_pkg::*;
#(
  parameter int FB_W   = 5,
  parameter int FB_H   = 5,
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [DIM_W-1:0]  cmdX,
  input  logic [DIM_W-1:0]  cmdY,
  input  logic [DIM_W-1:0]  cmdWidth,
  input  logic [DIM_W-1:0]  cmdHeight,
  input  logic [DIM_W-1:0]  cmdPitch,
  input  logic              lumaValid,
  input  logic              bitAvail,
  output logic              cmdReady,
  output logic              lumaReady,
  output fbw_strobe_t       strobe,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              cmdErr
);
  localparam int PIX = FB_W * FB_H;
  localparam int WIDE = ADDR_W + DIM_W + 1;
  localparam logic [DIM_W:0] W_LIM = (DIM_W+1)'(FB_W);
  localparam logic [DIM_W:0] H_LIM = (DIM_W+1)'(FB_H);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PIX - 1);

  fbw_state_t state;
  logic [DIM_W-1:0]  col, row, skip, winW, winH, pad;
  logic [ADDR_W-1:0] rowBase, scanIdx;

  logic badCmd, emptyCmd, accept, lumaGo;
  logic inPix, rowEnd, lastRow;
  logic [WIDE-1:0] startAddr;

  always_comb begin
    badCmd = ({1'b0, cmdX} >= W_LIM) ||
             ({1'b0, cmdX} + {1'b0, cmdWidth} > W_LIM) ||
             ({1'b0, cmdY} >= H_LIM) ||
             ({1'b0, cmdY} + {1'b0, cmdHeight} > H_LIM) ||
             (cmdPitch < cmdWidth);
    emptyCmd  = (cmdHeight == '0) || (cmdPitch == '0);
    startAddr = WIDE'(cmdY) * WIDE'(FB_W) + WIDE'(cmdX);
  end

  assign cmdReady  = (state == ST_IDLE);
  assign lumaReady = (state == ST_IDLE) && !cmdValid;
  assign accept    = cmdReady && cmdValid;
  assign lumaGo    = lumaReady && lumaValid;

  always_comb begin
    inPix   = (col < winW);
    rowEnd  = inPix ? ((col + 1'b1 == winW) && (pad == '0))
                    : (skip + 1'b1 == pad);
    lastRow = (row + 1'b1 == winH);

    strobe          = '0;
    strobe.wantBit  = (state == ST_RUN);
    strobe.takeBit  = (state == ST_RUN) && bitAvail;
    strobe.writePix = strobe.takeBit && inPix;
    strobe.flush    = accept;
    strobe.loadLuma = lumaGo;
    strobe.scanStep = (state == ST_SCAN);

    addr = (state == ST_SCAN) ? scanIdx : rowBase + ADDR_W'(col);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      col     <= '0;
      row     <= '0;
      skip    <= '0;
      winW    <= '0;
      winH    <= '0;
      pad     <= '0;
      rowBase <= '0;
      scanIdx <= '0;
      done    <= 1'b0;
      cmdErr  <= 1'b0;
    end else begin
      done   <= 1'b0;
      cmdErr <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (badCmd) begin
              cmdErr <= 1'b1;
            end else if (emptyCmd) begin
              done <= 1'b1;
            end else begin
              state   <= ST_RUN;
              winW    <= cmdWidth;
              winH    <= cmdHeight;
              pad     <= cmdPitch - cmdWidth;
              col     <= '0;
              row     <= '0;
              skip    <= '0;
              rowBase <= ADDR_W'(startAddr);
            end
          end else if (lumaGo) begin
            state   <= ST_SCAN;
            scanIdx <= '0;
          end
        end
        ST_RUN: begin
          if (strobe.takeBit) begin
            if (rowEnd) begin
              col     <= '0;
              skip    <= '0;
              row     <= row + 1'b1;
              rowBase <= rowBase + ADDR_W'(FB_W);
              if (lastRow) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end else if (inPix) begin
              col <= col + 1'b1;
            end else begin
              skip <= skip + 1'b1;
            end
          end
        end
        ST_SCAN: begin
          scanIdx <= scanIdx + 1'b1;
          if (scanIdx == LAST_ADDR) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  err_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> (state == ST_IDLE) && $past(cmdValid));

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, cmdErr}));

  // R8
  scan_no_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scanStep |-> !lumaReady && !strobe.wantBit);
endmodule

// File: rtl/fbw_datapath.sv
module fbw_datapath
  import fbw_pkg::*;
#(
  parameter int FB_W   = 5,
  parameter int FB_H   = 5,
  parameter int LUMA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbw_strobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [LUMA_W-1:0] lumaReq,
  output logic              bitAvail,
  output logic              byteReady,
  output logic              fbWe,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [LUMA_W-1:0] fbData
);
  localparam int PIX = FB_W * FB_H;
  localparam int POS_W = $clog2(BYTE_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTE_W - 1);
  localparam logic [LUMA_W-1:0] L_MAX = '1;
  localparam logic [LUMA_W-1:0] L_MIN = LUMA_W'(1);
  localparam logic signed [LUMA_W+1:0] S_ONE = (LUMA_W+2)'(1);
  localparam logic signed [LUMA_W+1:0] S_MAX = $signed({2'b00, L_MAX});

  logic [LUMA_W-1:0] pixMem [PIX];
  logic [BYTE_W-1:0] heldByte;
  logic [POS_W-1:0]  bitPos;
  logic              haveByte;
  logic [LUMA_W-1:0] lumaReg;
  logic signed [LUMA_W:0] deltaReg;

  logic              curBit;
  logic [LUMA_W-1:0] reqClamped, oldPix, scanNew;
  logic signed [LUMA_W+1:0] sumS;

  // bit unpacker, bit 0 of each byte first
  assign bitAvail  = haveByte || byteValid;
  assign byteReady = strobe.wantBit && !haveByte;
  assign curBit    = haveByte ? heldByte[bitPos] : byteData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldByte <= '0;
      bitPos   <= '0;
      haveByte <= 1'b0;
    end else if (strobe.flush) begin
      haveByte <= 1'b0;
    end else if (strobe.takeBit) begin
      if (haveByte) begin
        bitPos <= bitPos + 1'b1;
        if (bitPos == LAST_POS) haveByte <= 1'b0;
      end else begin
        heldByte <= byteData;
        bitPos   <= POS_W'(1);
        haveByte <= 1'b1;
      end
    end
  end

  // brightness and rescale arithmetic
  assign reqClamped = (lumaReq == '0) ? L_MIN : lumaReq;
  assign oldPix     = pixMem[addr];

  always_comb begin
    sumS = $signed({2'b00, oldPix}) + $signed({deltaReg[LUMA_W], deltaReg});
    if (sumS < S_ONE)      scanNew = L_MIN;
    else if (sumS > S_MAX) scanNew = L_MAX;
    else                   scanNew = sumS[LUMA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lumaReg  <= L_MAX;
      deltaReg <= '0;
    end else if (strobe.loadLuma) begin
      lumaReg  <= reqClamped;
      deltaReg <= $signed({1'b0, reqClamped}) - $signed({1'b0, lumaReg});
    end
  end

  // framebuffer write port and storage
  always_comb begin
    fbWe   = strobe.writePix || (strobe.scanStep && (oldPix != '0));
    fbAddr = addr;
    fbData = strobe.writePix ? (curBit ? lumaReg : '0) : scanNew;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PIX; i++) pixMem[i] <= '0;
    end else if (fbWe) begin
      pixMem[fbAddr] <= fbData;
    end
  end

  // R6
  luma_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lumaReg != '0);

  // R7
  scan_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.scanStep && fbWe) |-> (fbData != '0));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    fbWe |-> (int'(fbAddr) < PIX));

  // R8
  scan_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.scanStep && $past(strobe.scanStep)) |-> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/mono_fb_writer.sv
module mono_fb_writer
  import fbw_pkg::*;
#(
  parameter int FB_W   = 5,
  parameter int FB_H   = 5,
  parameter int DIM_W  = 8,
  parameter int LUMA_W = 8,
  localparam int ADDR_W = (FB_W * FB_H > 1) ? $clog2(FB_W * FB_H) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [DIM_W-1:0]  cmdX,
  input  logic [DIM_W-1:0]  cmdY,
  input  logic [DIM_W-1:0]  cmdWidth,
  input  logic [DIM_W-1:0]  cmdHeight,
  input  logic [DIM_W-1:0]  cmdPitch,
  output logic              cmdReady,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              byteReady,
  input  logic              lumaValid,
  input  logic [LUMA_W-1:0] lumaReq,
  output logic              lumaReady,
  output logic              fbWe,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [LUMA_W-1:0] fbData,
  output logic              done,
  output logic              cmdErr
);
  fbw_strobe_t       strobe;
  logic [ADDR_W-1:0] addr;
  logic              bitAvail;

  fbw_ctrl #(
    .FB_W(FB_W), .FB_H(FB_H), .DIM_W(DIM_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdX(cmdX), .cmdY(cmdY),
    .cmdWidth(cmdWidth), .cmdHeight(cmdHeight), .cmdPitch(cmdPitch),
    .lumaValid(lumaValid), .bitAvail(bitAvail),
    .cmdReady(cmdReady), .lumaReady(lumaReady),
    .strobe(strobe), .addr(addr), .done(done), .cmdErr(cmdErr)
  );

  fbw_datapath #(
    .FB_W(FB_W), .FB_H(FB_H), .LUMA_W(LUMA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .byteValid(byteValid), .byteData(byteData), .lumaReq(lumaReq),
    .bitAvail(bitAvail), .byteReady(byteReady),
    .fbWe(fbWe), .fbAddr(fbAddr), .fbData(fbData)
  );
endmodule

// File: tb/mono_fb_writer_tb.sv
module mono_fb_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam int H = 5;
  localparam int PIX = W * H;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdX = '0, cmdY = '0, cmdWidth = '0, cmdHeight = '0, cmdPitch = '0;
  logic       cmdReady;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       byteReady;
  logic       lumaValid = 1'b0;
  logic [7:0] lumaReq = '0;
  logic       lumaReady;
  logic       fbWe;
  logic [4:0] fbAddr;
  logic [7:0] fbData;
  logic       done, cmdErr;

  mono_fb_writer #(.FB_W(W), .FB_H(H)) u_dut (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdX(cmdX), .cmdY(cmdY),
    .cmdWidth(cmdWidth), .cmdHeight(cmdHeight), .cmdPitch(cmdPitch),
    .cmdReady(cmdReady),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .lumaValid(lumaValid), .lumaReq(lumaReq), .lumaReady(lumaReady),
    .fbWe(fbWe), .fbAddr(fbAddr), .fbData(fbData),
    .done(done), .cmdErr(cmdErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int model [PIX];
  int luma = 255;
  int expA [64];
  int expD [64];
  int ne;
  int bytes [16];

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampL(input int v);
    return (v < 1) ? 1 : ((v > 255) ? 255 : v);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    summary();
  end

  task automatic runWindow(input int x, input int y, input int w, input int h, input int p);
    bit bad;
    int nb, nbytes, bi, wi, doneCnt, errCnt, tail;
    bad = (x >= W) || (x + w > W) || (y >= H) || (y + h > H) || (p < w);
    nb = bad ? 0 : h * p;
    nbytes = (nb + 7) / 8;
    for (int i = 0; i < 16; i++) bytes[i] = int'($urandom % 256);
    ne = 0;
    if (!bad)
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          int idx;
          idx = r * p + c;
          expA[ne] = (y + r) * W + x + c;
          expD[ne] = ((bytes[idx / 8] >> (idx % 8)) & 1) ? luma : 0;
          ne++;
        end
    @(negedge clk);
    cmdX = 8'(x); cmdY = 8'(y); cmdWidth = 8'(w); cmdHeight = 8'(h); cmdPitch = 8'(p);
    cmdValid = 1'b1;
    #1 chk(cmdReady == 1'b1, "R10 idle before command", int'(cmdReady), 1);
    @(negedge clk);
    cmdValid = 1'b0;
    bi = 0; wi = 0; doneCnt = 0; errCnt = 0; tail = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      byteValid = bad ? 1'b1 : ((bi < nbytes) && ($urandom % 4 != 0));
      byteData  = 8'(bytes[bi % 16]);
      #1;
      if (byteReady && byteValid) bi++;
      if (fbWe) begin
        if (wi < ne) begin
          chk(int'(fbAddr) == expA[wi], "R3 address", int'(fbAddr), expA[wi]);
          chk(int'(fbData) == expD[wi], "R2/R4/R6 pixel value", int'(fbData), expD[wi]);
        end else begin
          chk(1'b0, "R1 unexpected write", wi, ne);
        end
        wi++;
      end
      if (done) begin
        doneCnt++;
        chk(wi == ne, "R9 done after last pixel", wi, ne);
        chk(bi == nbytes, "R5 bytes used at done", bi, nbytes);
      end
      if (cmdErr) errCnt++;
      if ((doneCnt + errCnt) > 0) tail++;
      if (tail > 2) break;
      @(negedge clk);
    end
    byteValid = 1'b0;
    chk(doneCnt == (bad ? 0 : 1), "R9 done pulse count", doneCnt, bad ? 0 : 1);
    chk(errCnt == (bad ? 1 : 0), "R1 error pulse count", errCnt, bad ? 1 : 0);
    if (bad) chk(bi == 0 && wi == 0, "R1 nothing consumed or written", bi + wi, 0);
    for (int i = 0; i < ne; i++) model[expA[i]] = expD[i];
  endtask

  task automatic runLuma(input int req);
    int nl, delta, wi, busy;
    nl = (req == 0) ? 1 : req;
    delta = nl - luma;
    ne = 0;
    for (int a = 0; a < PIX; a++)
      if (model[a] != 0) begin
        expA[ne] = a;
        expD[ne] = clampL(model[a] + delta);
        ne++;
      end
    luma = nl;
    @(negedge clk);
    lumaReq = 8'(req);
    lumaValid = 1'b1;
    #1 chk(lumaReady == 1'b1, "R8 brightness taken when idle", int'(lumaReady), 1);
    @(negedge clk);
    lumaValid = 1'b0;
    wi = 0; busy = 0;
    for (int cyc = 0; cyc < 100; cyc++) begin
      #1;
      if (fbWe) begin
        if (wi < ne) begin
          chk(int'(fbAddr) == expA[wi], "R7 rescale address", int'(fbAddr), expA[wi]);
          chk(int'(fbData) == expD[wi], "R7 rescale value", int'(fbData), expD[wi]);
        end else begin
          chk(1'b0, "R7 write to dark pixel", int'(fbAddr), -1);
        end
        wi++;
      end
      if (cmdReady) break;
      if (lumaReady) chk(1'b0, "R8 brightness ready during rescale", 1, 0);
      busy++;
      @(negedge clk);
    end
    chk(busy == PIX, "R8 rescale length", busy, PIX);
    chk(wi == ne, "R7 rescale write count", wi, ne);
    for (int i = 0; i < ne; i++) model[expA[i]] = expD[i];
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < PIX; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(cmdReady == 1'b1, "R10 reset ready", int'(cmdReady), 1);
    chk(byteReady == 1'b0, "R2 reset no byte request", int'(byteReady), 0);
    chk(fbWe == 1'b0, "R3 reset no write", int'(fbWe), 0);
    chk(done == 1'b0 && cmdErr == 1'b0, "R9 reset pulses low", int'(done) + int'(cmdErr), 0);

    // full frame, bytes cross rows, reset brightness 255
    runWindow(0, 0, 5, 5, 5);
    // padding bits
    runWindow(1, 1, 3, 2, 7);
    runWindow(0, 4, 5, 1, 13);
    runWindow(4, 0, 1, 5, 3);
    // R1 refusals
    runWindow(5, 0, 1, 1, 1);
    runWindow(3, 0, 3, 1, 3);
    runWindow(0, 5, 1, 1, 1);
    runWindow(0, 3, 1, 3, 1);
    runWindow(0, 0, 3, 1, 2);
    // R9 empty windows
    runWindow(2, 2, 0, 3, 4);
    runWindow(1, 1, 2, 0, 2);
    runWindow(0, 0, 0, 0, 0);
    // R6 / R7 brightness
    runLuma(0);
    runWindow(0, 0, 5, 2, 5);
    runLuma(200);
    runLuma(255);
    runLuma(40);
    runWindow(1, 2, 4, 3, 9);
    runLuma(1);
    runLuma(128);

    for (int n = 0; n < 60; n++) begin
      if ($urandom % 5 == 0) runLuma(int'($urandom % 256));
      else runWindow(int'($urandom % 7), int'($urandom % 7), int'($urandom % 6),
                     int'($urandom % 6), int'($urandom % 16));
    end
    summary();
  end
endmodule